// File: doc/BRIEF.md
# TDMA Domain Bridge

This block joins two locally synchronous sub-networks that each keep their own time-slot table. Packets leaving the upstream sub-network enter the bridge one at a time. A queue number carried in the header steers each packet into one of several small packet queues. Inside the receiving sub-network the bridge behaves like an ordinary network interface. A programmable reservation table, stepped by the receiving domain's slot counter, picks which queue may send in each slot. The chosen packet leaves as three consecutive 32-bit phits: the header, then the upper and lower halves of a one-flit payload.

On the way out, the upstream route field is removed and a route valid inside the new sub-network is written in its place. That route is looked up from the queue number. Every packet that leaves a queue sends a credit pulse, tagged with the queue number, back toward the upstream sender. Each queue also reports a full flag to the upstream side.

A build-time option covers the case where both tables emit and consume in the same order. In that case one queue serves all traffic and the queue number is cleared from the outgoing header. The bridge is modelled on a single clock. Sizing the reservations is left to the table programmer: a stream needs at least (payload rate / link frequency) × table length plus (headers per rotation × header phits / slot phits) slots.

Top module: `tdma_bridge_sync`

## Requirements
- R1: After reset, out_valid, out_first, out_phit, cr_valid, cr_qid and every bit of q_full are 0, and every reservation entry is disabled, so no packet leaves until the table is written.
- R2: An accepted packet (in_valid high) is stored in the queue named by header bits [31:28].
- R3: A queue holding QDEPTH packets shows its q_full bit high. A write aimed at a full queue is ignored, even in a cycle where that queue is also read.
- R4: A packet whose header bits [31:28] hold a value of NQ or more is discarded and changes no queue.
- R5: A slot lasts three cycles and the slot index counts 0 to SLOTS-1, then wraps to 0; slot 0 starts in the first cycle after reset is released. When a packet is served in a slot, out_valid is high for the three cycles that start one cycle after the slot begins. out_first is high only in the first of those cycles. out_phit carries the header, then payload bits [63:32], then payload bits [31:0].
- R6: A slot whose reservation entry is disabled sends nothing.
- R7: A slot reserved for an empty queue stays idle; no other queue is served in it.
- R8: In the outgoing header, bits [15:0] are replaced by the route programmed for the packet's queue and bits [31:16] pass unchanged.
- R9: Each packet taken from a queue raises cr_valid for one cycle, with cr_qid equal to that queue, in the same cycle as its out_first.
- R10: With COHERENT set, every packet goes to a single queue whatever its header queue field. The outgoing header has bits [31:28] cleared and takes the route of entry 0. Reservations use only their enable bit, and all q_full bits copy the single queue's full state.
- R11: A table write (tbl_we with tbl_slot, tbl_qid, tbl_en) or route write (rt_we with rt_qid, rt_path) is used by every slot decision after the write cycle.
- R12: Packets of one queue leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming packet present this cycle |
| in_hdr | input | 32 | Incoming header phit: [31:28] queue number, [15:0] old route |
| in_payload | input | 64 | Incoming one-flit payload |
| q_full | output | NQ | Per-queue full flag toward the upstream side |
| tbl_we | input | 1 | Reservation table write strobe |
| tbl_slot | input | SW | Slot index to write |
| tbl_qid | input | QW | Queue reserved for that slot |
| tbl_en | input | 1 | Entry enable written with the slot |
| rt_we | input | 1 | Route table write strobe |
| rt_qid | input | QW | Queue whose route is written |
| rt_path | input | 16 | Route field for that queue |
| out_valid | output | 1 | Outgoing phit valid |
| out_first | output | 1 | Outgoing phit is a header |
| out_phit | output | 32 | Outgoing phit, 0 when idle |
| cr_valid | output | 1 | Credit pulse toward the upstream side |
| cr_qid | output | QW | Queue that freed a place, 0 when idle |

## Verification
The hardest case to reach is a single cycle that hits one queue three ways at once: its reserved slot begins, a new packet arrives for it, and it is already full. The write must be refused even though a place frees up in that same cycle. The directed part of the bench fills the slot-six queue past its depth, with writes straddling the slot boundary. The random part keeps writes dense on a small set of queue numbers, so full queues meet their own read slots many times. A reference model checks every output in every cycle, for both the normal and the coherent variant.

// File: rtl/tdma_bridge_pkg.sv
package tdma_bridge_pkg;
    localparam int PHIT_W   = 32;
    localparam int PAY_W    = 2 * PHIT_W;
    localparam int QID_LSB  = 28;
    localparam int QIDF_W   = 4;
    localparam int ROUTE_W  = 16;
    localparam int SLOT_PH  = 3;

    typedef struct packed {
        logic [PHIT_W-1:0] hdr;
        logic [PAY_W-1:0]  pay;
    } pkt_t;
endpackage

// File: rtl/tdma_bridge_fifo.sv
module tdma_bridge_fifo
    import tdma_bridge_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  pkt_t data_i,
    input  logic pop_i,
    output pkt_t data_o,
    output logic empty_o,
    output logic full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][$bits(pkt_t)-1:0] mem;
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            s_d.mem[s_q.wp] = data_i;
            s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (do_pop) begin
            s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_o  = pkt_t'(s_q.mem[s_q.rp]);
    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == CW'(DEPTH));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o) else $error("read of empty queue"); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> full_o) else $error("full queue changed"); // R3
endmodule

// File: rtl/tdma_bridge_sched.sv
module tdma_bridge_sched
    import tdma_bridge_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int SLOTS    = 8,
    parameter bit COHERENT = 1'b0,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tbl_we,
    input  logic [SW-1:0] tbl_slot,
    input  logic [QW-1:0] tbl_qid,
    input  logic          tbl_en,
    input  logic [NQ-1:0] q_empty,
    output logic          pop_o,
    output logic [QW-1:0] pop_qid_o
);
    typedef struct packed {
        logic [SLOTS-1:0]         en;
        logic [SLOTS-1:0][QW-1:0] qsel;
        logic [1:0]               phase;
        logic [SW-1:0]            slot;
    } sch_st_t;

    sch_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.phase == 2'(SLOT_PH - 1)) begin
            s_d.phase = '0;
            s_d.slot  = (s_q.slot == SW'(SLOTS - 1)) ? '0 : s_q.slot + 1'b1;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
        if (tbl_we) begin
            s_d.en[tbl_slot]   = tbl_en;
            s_d.qsel[tbl_slot] = COHERENT ? '0 : tbl_qid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        pop_qid_o = COHERENT ? '0 : s_q.qsel[s_q.slot];
        pop_o     = (s_q.phase == '0) && s_q.en[s_q.slot] && !q_empty[pop_qid_o];
    end

    AST_ONE_POP_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |=> !pop_o) else $error("two reads in one slot"); // R5
endmodule

// File: rtl/tdma_bridge_route.sv
module tdma_bridge_route
    import tdma_bridge_pkg::*;
#(
    parameter int NQ = 4,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rt_we,
    input  logic [QW-1:0] rt_qid,
    input  logic [ROUTE_W-1:0] rt_path,
    input  logic [QW-1:0] rd_qid,
    output logic [ROUTE_W-1:0] rd_path
);
    typedef struct packed {
        logic [NQ-1:0][ROUTE_W-1:0] path;
    } rt_st_t;

    rt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rt_we) begin
            s_d.path[rt_qid] = rt_path;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_path = s_q.path[rd_qid];
endmodule

// File: rtl/tdma_bridge_sync.sv
module tdma_bridge_sync
    import tdma_bridge_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int QDEPTH   = 4,
    parameter int SLOTS    = 8,
    parameter bit COHERENT = 1'b0,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   in_hdr,
    input  logic [63:0]   in_payload,
    output logic [NQ-1:0] q_full,
    input  logic          tbl_we,
    input  logic [SW-1:0] tbl_slot,
    input  logic [QW-1:0] tbl_qid,
    input  logic          tbl_en,
    input  logic          rt_we,
    input  logic [QW-1:0] rt_qid,
    input  logic [15:0]   rt_path,
    output logic          out_valid,
    output logic          out_first,
    output logic [31:0]   out_phit,
    output logic          cr_valid,
    output logic [QW-1:0] cr_qid
);
    localparam int NQI = COHERENT ? 1 : NQ;

    typedef struct packed {
        logic                 ov;
        logic                 of;
        logic [PHIT_W-1:0]    ph;
        logic [1:0]           rem;
        logic [PAY_W-1:0]     hold;
        logic                 cv;
        logic [QW-1:0]        cq;
    } ser_st_t;

    ser_st_t s_d, s_q;

    logic [QIDF_W-1:0] in_qf;
    logic              in_ok;
    logic [NQI-1:0]    push, pop_v, empty_v, full_v;
    pkt_t              fdata [NQI];
    pkt_t              sel;
    logic [NQ-1:0]     empty_ext;
    logic              pop;
    logic [QW-1:0]     pop_qid;
    logic [ROUTE_W-1:0] new_route;
    logic [PHIT_W-1:0] new_hdr;

    assign in_qf = in_hdr[QID_LSB +: QIDF_W];
    assign in_ok = in_valid && (COHERENT || (int'(in_qf) < NQ));

    for (genvar gi = 0; gi < NQI; gi++) begin : g_q
        assign push[gi]  = in_ok && (COHERENT || (int'(in_qf) == gi));
        assign pop_v[gi] = pop && (int'(pop_qid) == gi);
        tdma_bridge_fifo #(.DEPTH(QDEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (push[gi]),
            .data_i  (pkt_t'({in_hdr, in_payload})),
            .pop_i   (pop_v[gi]),
            .data_o  (fdata[gi]),
            .empty_o (empty_v[gi]),
            .full_o  (full_v[gi])
        );
    end

    if (COHERENT) begin : g_coh
        assign empty_ext = {NQ{empty_v[0]}};
        assign q_full    = {NQ{full_v[0]}};
    end else begin : g_multi
        assign empty_ext = empty_v;
        assign q_full    = full_v;
    end

    tdma_bridge_sched #(.NQ(NQ), .SLOTS(SLOTS), .COHERENT(COHERENT)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_we    (tbl_we),
        .tbl_slot  (tbl_slot),
        .tbl_qid   (tbl_qid),
        .tbl_en    (tbl_en),
        .q_empty   (empty_ext),
        .pop_o     (pop),
        .pop_qid_o (pop_qid)
    );

    tdma_bridge_route #(.NQ(NQ)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .rt_we   (rt_we),
        .rt_qid  (rt_qid),
        .rt_path (rt_path),
        .rd_qid  (pop_qid),
        .rd_path (new_route)
    );

    always_comb begin
        sel = fdata[0];
        for (int i = 0; i < NQI; i++) begin
            if (int'(pop_qid) == i) sel = fdata[i];
        end
        new_hdr = {sel.hdr[PHIT_W-1:ROUTE_W], new_route};
        if (COHERENT) new_hdr[QID_LSB +: QIDF_W] = '0;
    end

    always_comb begin
        s_d    = s_q;
        s_d.cv = pop;
        s_d.cq = pop ? pop_qid : '0;
        if (pop) begin
            s_d.ov   = 1'b1;
            s_d.of   = 1'b1;
            s_d.ph   = new_hdr;
            s_d.hold = sel.pay;
            s_d.rem  = 2'd2;
        end else if (s_q.rem != '0) begin
            s_d.ov   = 1'b1;
            s_d.of   = 1'b0;
            s_d.ph   = s_q.hold[PAY_W-1 -: PHIT_W];
            s_d.hold = {s_q.hold[PHIT_W-1:0], {PHIT_W{1'b0}}};
            s_d.rem  = s_q.rem - 1'b1;
        end else begin
            s_d.ov = 1'b0;
            s_d.of = 1'b0;
            s_d.ph = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.ov;
    assign out_first = s_q.of;
    assign out_phit  = s_q.ph;
    assign cr_valid  = s_q.cv;
    assign cr_qid    = s_q.cq;

    AST_FRAME_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |=> (out_valid && !out_first)) else $error("header without body"); // R5
    AST_FRAME_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_first && $past(out_first)) |=> (out_valid && !out_first))
        else $error("short frame"); // R5
    AST_CREDIT_WITH_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> out_first) else $error("credit without header"); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_phit == '0)) else $error("idle phit not zero"); // R6
endmodule

// File: tb/tdma_bridge_sync_bench.sv
`timescale 1ns/1ps
module tdma_bridge_ref #(
    parameter int NQ = 4, parameter int QD = 4, parameter int SLOTS = 8,
    parameter bit COH = 1'b0, parameter int QW = 2, parameter int SW = 3
) (
    input  logic clk, input logic rst_n,
    input  logic in_valid, input logic [31:0] in_hdr, input logic [63:0] in_payload,
    input  logic tbl_we, input logic [SW-1:0] tbl_slot, input logic [QW-1:0] tbl_qid,
    input  logic tbl_en, input logic rt_we, input logic [QW-1:0] rt_qid,
    input  logic [15:0] rt_path,
    output logic e_valid, output logic e_first, output logic [31:0] e_phit,
    output logic e_cr, output logic [QW-1:0] e_crq, output logic [NQ-1:0] e_full
);
    logic [95:0] mem [NQ][QD];
    int          cnt [NQ];
    logic        tv  [SLOTS];
    int          tq  [SLOTS];
    logic [15:0] rt  [NQ];
    int          phase, slot, rem;
    logic [63:0] hold;
    int          q, wq;
    bit          pop, acc;
    logic [95:0] item;
    logic [31:0] h;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) begin cnt[i] = 0; rt[i] = '0; end
            for (int i = 0; i < SLOTS; i++) begin tv[i] = 1'b0; tq[i] = 0; end
            phase = 0; slot = 0; rem = 0; hold = '0;
            e_valid <= 1'b0; e_first <= 1'b0; e_phit <= '0;
            e_cr <= 1'b0; e_crq <= '0; e_full <= '0;
        end else begin
            q   = COH ? 0 : tq[slot];
            pop = (phase == 0) && tv[slot] && (cnt[q] > 0);
            wq  = COH ? 0 : int'(in_hdr[31:28]);
            acc = in_valid && (wq < NQ) && (cnt[wq < NQ ? wq : 0] < QD);
            item = '0;
            if (pop) begin
                item = mem[q][0];
                for (int k = 0; k < QD - 1; k++) mem[q][k] = mem[q][k+1];
                cnt[q] = cnt[q] - 1;
            end
            if (acc) begin
                mem[wq][cnt[wq]] = {in_hdr, in_payload};
                cnt[wq] = cnt[wq] + 1;
            end
            if (pop) begin
                h = {item[95:80], rt[q]};
                if (COH) h[31:28] = 4'h0;
                e_valid <= 1'b1; e_first <= 1'b1; e_phit <= h;
                hold = item[63:0]; rem = 2;
                e_cr <= 1'b1; e_crq <= QW'(q);
            end else begin
                e_cr <= 1'b0; e_crq <= '0;
                if (rem > 0) begin
                    e_valid <= 1'b1; e_first <= 1'b0; e_phit <= hold[63:32];
                    hold = {hold[31:0], 32'h0}; rem = rem - 1;
                end else begin
                    e_valid <= 1'b0; e_first <= 1'b0; e_phit <= '0;
                end
            end
            if (tbl_we) begin tv[tbl_slot] = tbl_en; tq[tbl_slot] = int'(tbl_qid); end
            if (rt_we) rt[rt_qid] = rt_path;
            if (phase == 2) begin phase = 0; slot = (slot == SLOTS - 1) ? 0 : slot + 1; end
            else phase = phase + 1;
            for (int i = 0; i < NQ; i++) e_full[i] <= (cnt[COH ? 0 : i] == QD);
        end
    end
endmodule

module tdma_bridge_sync_bench;
    localparam int NQ = 4, QD = 4, SLOTS = 8, QW = 2, SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_hdr = '0;
    logic [63:0] in_payload = '0;
    logic tbl_we = 1'b0, tbl_en = 1'b0, rt_we = 1'b0;
    logic [SW-1:0] tbl_slot = '0;
    logic [QW-1:0] tbl_qid = '0, rt_qid = '0;
    logic [15:0] rt_path = '0;

    logic [NQ-1:0] q_full, q_full_c, x_full, x_full_c;
    logic ov, of, cv, ov_c, of_c, cv_c;
    logic [31:0] oph, oph_c;
    logic [QW-1:0] cq, cq_c;
    logic xv, xf, xc, xv_c, xf_c, xc_c;
    logic [31:0] xp, xp_c;
    logic [QW-1:0] xq, xq_c;

    int checks = 0, errors = 0, cyc = 0;
    bit run_cmp = 1'b0;
    string ptag = "R1";

    always #4 clk = ~clk;

    tdma_bridge_sync #(.NQ(NQ), .QDEPTH(QD), .SLOTS(SLOTS), .COHERENT(1'b0)) u_tdma_bridge_sync (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr), .in_payload(in_payload),
        .q_full(q_full), .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_qid(tbl_qid), .tbl_en(tbl_en),
        .rt_we(rt_we), .rt_qid(rt_qid), .rt_path(rt_path), .out_valid(ov), .out_first(of),
        .out_phit(oph), .cr_valid(cv), .cr_qid(cq));

    tdma_bridge_sync #(.NQ(NQ), .QDEPTH(QD), .SLOTS(SLOTS), .COHERENT(1'b1)) u_tdma_bridge_sync_coh (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr), .in_payload(in_payload),
        .q_full(q_full_c), .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_qid(tbl_qid), .tbl_en(tbl_en),
        .rt_we(rt_we), .rt_qid(rt_qid), .rt_path(rt_path), .out_valid(ov_c), .out_first(of_c),
        .out_phit(oph_c), .cr_valid(cv_c), .cr_qid(cq_c));

    tdma_bridge_ref #(.NQ(NQ), .QD(QD), .SLOTS(SLOTS), .COH(1'b0), .QW(QW), .SW(SW)) u_ref (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr), .in_payload(in_payload),
        .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_qid(tbl_qid), .tbl_en(tbl_en), .rt_we(rt_we),
        .rt_qid(rt_qid), .rt_path(rt_path), .e_valid(xv), .e_first(xf), .e_phit(xp),
        .e_cr(xc), .e_crq(xq), .e_full(x_full));

    tdma_bridge_ref #(.NQ(NQ), .QD(QD), .SLOTS(SLOTS), .COH(1'b1), .QW(QW), .SW(SW)) u_ref_coh (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr), .in_payload(in_payload),
        .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_qid(tbl_qid), .tbl_en(tbl_en), .rt_we(rt_we),
        .rt_qid(rt_qid), .rt_path(rt_path), .e_valid(xv_c), .e_first(xf_c), .e_phit(xp_c),
        .e_cr(xc_c), .e_crq(xq_c), .e_full(x_full_c));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] cycle %0d actual %h expected %h", tag, ptag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (run_cmp) begin
            check("R5 R6 R7 out_valid", 32'(ov), 32'(xv));
            check("R5 out_first", 32'(of), 32'(xf));
            check("R8 R12 R2 out_phit", oph, xp);
            check("R9 cr_valid", 32'(cv), 32'(xc));
            check("R9 cr_qid", 32'(cq), 32'(xq));
            check("R3 q_full", 32'(q_full), 32'(x_full));
            check("R10 coh out_valid", 32'(ov_c), 32'(xv_c));
            check("R10 coh out_first", 32'(of_c), 32'(xf_c));
            check("R10 coh out_phit", oph_c, xp_c);
            check("R10 coh credit", {cq_c, 1'b0, cv_c}, {xq_c, 1'b0, xc_c});
            check("R10 coh q_full", 32'(q_full_c), 32'(x_full_c));
        end
        if (cyc > 200000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk_hdr(int qid, int tag);
        return {4'(qid), 12'(tag), 16'hDEAD ^ 16'(tag)};
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(int qid, int tag);
        @(negedge clk);
        in_valid   = 1'b1;
        in_hdr     = mk_hdr(qid, tag);
        in_payload = {32'(tag) ^ 32'hA5A50000, 32'(tag) ^ 32'h0000C3C3};
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    task automatic wr_tbl(int s, int qid, bit en);
        @(negedge clk);
        tbl_we = 1'b1; tbl_slot = SW'(s); tbl_qid = QW'(qid); tbl_en = en;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic wr_rt(int qid, int path);
        @(negedge clk);
        rt_we = 1'b1; rt_qid = QW'(qid); rt_path = 16'(path);
        @(negedge clk);
        rt_we = 1'b0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20061);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every output
        @(negedge clk);
        check("R1 reset outputs", {30'h0, ov, cv}, 32'h0);
        check("R1 reset phit", oph, 32'h0);
        check("R1 reset full", 32'(q_full), 32'h0);
        run_cmp = 1'b1;
        // R1: disabled table sends nothing despite stored packets
        ptag = "R1 R6";
        send(0, 1);
        idle(30);
        // R11: routes and reservations programmed, then used
        ptag = "R11";
        for (int i = 0; i < NQ; i++) wr_rt(i, 16'h1000 + i * 16'h0111);
        wr_tbl(0, 0, 1'b1); wr_tbl(2, 1, 1'b1); wr_tbl(5, 2, 1'b1); wr_tbl(6, 3, 1'b1);
        idle(30);
        // R2 R12: ordered packets to two queues
        ptag = "R2 R12";
        for (int i = 0; i < 3; i++) send(1, 16 + i);
        for (int i = 0; i < 2; i++) send(0, 32 + i);
        idle(60);
        // R3: overfill queue 3 back to back
        ptag = "R3";
        @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            in_valid = 1'b1; in_hdr = mk_hdr(3, 64 + i); in_payload = {32'(i), 32'(~i)};
            @(negedge clk);
        end
        in_valid = 1'b0;
        idle(90);
        // R4: out of range queue numbers
        ptag = "R4";
        send(5, 80); send(15, 81); send(4, 82);
        idle(40);
        // R7: queue 2 empty in its slot, others stocked
        ptag = "R7";
        send(0, 90); send(1, 91); send(3, 92);
        idle(40);
        // R11: reprogram mid-run, disable slot 0, move queue 0 to slot 7
        ptag = "R11 R6";
        wr_tbl(0, 0, 1'b0); wr_tbl(7, 0, 1'b1); wr_rt(0, 16'hBEEF);
        send(0, 100); send(0, 101);
        idle(60);
        // random mixed traffic
        ptag = "R2 R3 R5 R8 R9 R12 random";
        for (int c = 0; c < 2500; c++) begin
            @(negedge clk);
            in_valid = ($urandom % 100) < 45;
            in_hdr = mk_hdr(($urandom % 10 == 0) ? 4 + ($urandom % 12) : ($urandom % NQ), $urandom % 4096);
            in_payload = {$urandom, $urandom};
            tbl_we = ($urandom % 50) == 0;
            tbl_slot = SW'($urandom); tbl_qid = QW'($urandom); tbl_en = ($urandom % 4) != 0;
            rt_we = ($urandom % 80) == 0;
            rt_qid = QW'($urandom); rt_path = 16'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0; tbl_we = 1'b0; rt_we = 1'b0;
        ptag = "drain";
        for (int s = 0; s < SLOTS; s++) wr_tbl(s, s % NQ, 1'b1);
        idle(200);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule